// File: doc/BRIEF.md
# Page Commit Engine with Upper-Half Write Lock

This block is the back end of a small serial memory. Once the bus front end has seen the Stop condition that ends a write transaction, it hands the engine a commit request. The request holds a page number, a sixteen-byte staging buffer and a sixteen-bit mask that marks which staged bytes hold data. The engine copies the marked bytes into a 128-byte storage array. It writes one byte per clock cycle, starting at the lowest marked offset and moving upward. Then it reports busy for a fixed, parameterised number of cycles, which stands in for the programming time of the memory.

A lock input guards the upper half of the array. The engine samples the lock once, in the cycle it accepts a request. If the lock is set and the page lies in the upper half, the engine writes nothing. It still reports busy for the full period, exactly as it would for a real write, so the upstream side sees identical timing whether or not the data landed. A registered read port lets the surrounding logic, and the testbench, inspect any array location.

Top module: `pgcommit_engine`

## Requirements
- R1: After a synchronous reset, `busy` is 0 and every array location reads back FFh.
- R2: A request is taken only when `req_valid` and `stop_det` are both 1 while `busy` is 0. A request presented with `stop_det` at 0 leaves `busy` at 0 and the array unchanged.
- R3: `busy` goes high in the cycle after the accepting clock edge and stays high for exactly `BUSY_CYCLES` cycles.
- R4: A request presented while `busy` is 1 is refused: it writes nothing and does not lengthen the busy period.
- R5: For each offset i (0 to 15) whose bit i of `req_mask` is 1, byte `req_data[8*i+7:8*i]` is stored at address `{req_page, i}`. Offsets whose mask bit is 0 keep their old contents.
- R6: All bytes of a commit land inside the addressed 16-byte page. No location outside that page changes.
- R7: When the lock is set at acceptance and `req_page[2]` is 1 (addresses 40h to 7Fh), nothing is written, yet `busy` still lasts `BUSY_CYCLES` cycles.
- R8: With the lock at 0, every page is writable. With the lock at 1, pages 0 to 3 (addresses 00h to 3Fh) remain writable.
- R9: The lock value used for a commit is the one sampled at acceptance. Changing `wp_in` while `busy` is high does not affect that commit.
- R10: Array writes happen one per cycle, only while `busy` is high, at strictly ascending addresses within a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Commit request present |
| stop_det | input | 1 | Bus Stop condition has been observed for this request |
| req_page | input | 3 | Page number (address bits 6:4) |
| req_data | input | 128 | Staged bytes; byte i at bits 8i+7:8i |
| req_mask | input | 16 | Bit i set: staged byte i is to be written |
| wp_in | input | 1 | Lock for the upper half of the array |
| busy | output | 1 | Commit in progress; new requests are refused |
| rd_addr | input | 7 | Read address |
| rd_data | output | 8 | Array byte at rd_addr, one cycle after the address |

## Verification
The checker assumes three things about the inputs: `req_valid` and `stop_det` arrive together as a single-cycle pulse, `BUSY_CYCLES` is at least as large as the page size, and `rd_addr` has no effect on what gets written. The stimulus drives each request for exactly one cycle at a falling edge. It issues every lock change either before a request or while `busy` is high. It reads the array only through the registered read port, and only after `busy` has dropped. The bench default for the busy length is 24 cycles, which leaves room for a full sixteen-byte page.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    localparam int unsigned PGC_ADDR_W = 7;
    localparam int unsigned PGC_OFS_W  = 4;
    localparam int unsigned PGC_DATA_W = 8;
    localparam logic [7:0]  PGC_ERASED = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_HOLD  = 2'd2
    } pgc_state_e;

    // A page is locked when the lock is set and the page sits in the upper half.
    function automatic logic pgc_blocked(input logic lock, input logic upper_half);
        return lock & upper_half;
    endfunction

endpackage

// File: rtl/pgc_pick.sv
module pgc_pick #(
    parameter int unsigned N = 16,
    localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         hit,
    output logic [W-1:0] idx
);
    // Lowest set bit wins.
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/pgc_seq.sv
module pgc_seq
    import pgc_pkg::*;
#(
    parameter int unsigned ADDR_W      = PGC_ADDR_W,
    parameter int unsigned OFS_W       = PGC_OFS_W,
    parameter int unsigned DATA_W      = PGC_DATA_W,
    parameter int unsigned BUSY_CYCLES = 40,
    localparam int unsigned PAGE_BYTES = 1 << OFS_W,
    localparam int unsigned PG_W       = ADDR_W - OFS_W,
    localparam int unsigned CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic                         stop_det,
    input  logic [PG_W-1:0]              req_page,
    input  logic [PAGE_BYTES*DATA_W-1:0] req_data,
    input  logic [PAGE_BYTES-1:0]        req_mask,
    input  logic                         wp_in,
    output logic                         busy,
    output logic                         wr_en,
    output logic [ADDR_W-1:0]            wr_addr,
    output logic [DATA_W-1:0]            wr_data
);
    pgc_state_e                  state_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [PG_W-1:0]             page_q;
    logic [PAGE_BYTES*DATA_W-1:0] data_q;
    logic [PAGE_BYTES-1:0]       pend_q;
    logic [PAGE_BYTES-1:0]       pend_nx;
    logic                        sel_hit;
    logic [OFS_W-1:0]            sel_idx;
    logic                        accept;
    logic                        blocked;

    pgc_pick #(.N(PAGE_BYTES)) u_pick (
        .vec (pend_q),
        .hit (sel_hit),
        .idx (sel_idx)
    );

    assign accept  = req_valid && stop_det && (state_q == ST_IDLE);
    assign blocked = pgc_blocked(wp_in, req_page[PG_W-1]);
    assign pend_nx = pend_q & ~(PAGE_BYTES'(1) << sel_idx);

    assign busy    = (state_q != ST_IDLE);
    assign wr_en   = (state_q == ST_WRITE) && sel_hit;
    assign wr_addr = {page_q, sel_idx};
    assign wr_data = data_q[sel_idx*DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            page_q  <= '0;
            data_q  <= '0;
            pend_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        page_q  <= req_page;
                        data_q  <= req_data;
                        pend_q  <= blocked ? '0 : req_mask;
                        cnt_q   <= CNT_W'(BUSY_CYCLES - 1);
                        state_q <= (blocked || (req_mask == '0)) ? ST_HOLD : ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    pend_q <= pend_nx;
                    cnt_q  <= cnt_q - 1'b1;
                    if (cnt_q == '0)         state_q <= ST_IDLE;
                    else if (pend_nx == '0)  state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == '0) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgc_array.sv
module pgc_array
    import pgc_pkg::*;
#(
    parameter int unsigned ADDR_W = PGC_ADDR_W,
    parameter int unsigned DATA_W = PGC_DATA_W,
    parameter logic [DATA_W-1:0] FILL = PGC_ERASED,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= FILL;
            rd_data <= FILL;
        end else begin
            if (wr_en) cells[wr_addr] <= wr_data;
            rd_data <= cells[rd_addr];
        end
    end
endmodule

// File: rtl/pgcommit_engine.sv
module pgcommit_engine
    import pgc_pkg::*;
#(
    parameter int unsigned ADDR_W      = PGC_ADDR_W,
    parameter int unsigned OFS_W       = PGC_OFS_W,
    parameter int unsigned DATA_W      = PGC_DATA_W,
    parameter int unsigned BUSY_CYCLES = 40,
    localparam int unsigned PAGE_BYTES = 1 << OFS_W,
    localparam int unsigned PG_W       = ADDR_W - OFS_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic                         stop_det,
    input  logic [PG_W-1:0]              req_page,
    input  logic [PAGE_BYTES*DATA_W-1:0] req_data,
    input  logic [PAGE_BYTES-1:0]        req_mask,
    input  logic                         wp_in,
    output logic                         busy,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    pgc_seq #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .stop_det(stop_det), .req_page(req_page),
        .req_data(req_data), .req_mask(req_mask), .wp_in(wp_in),
        .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    pgc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned OFS_W       = 4,
    parameter int unsigned BUSY_CYCLES = 40,
    localparam int unsigned PG_W       = ADDR_W - OFS_W,
    localparam int unsigned BC_W       = $clog2(BUSY_CYCLES + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              stop_det,
    input logic [PG_W-1:0]   req_page,
    input logic              wp_in,
    input logic              busy,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);
    logic [BC_W-1:0] bcnt;
    logic [PG_W-1:0] c_page;
    logic            c_lock;
    logic            take;

    assign take = req_valid && stop_det && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt   <= '0;
            c_page <= '0;
            c_lock <= 1'b0;
        end else begin
            bcnt <= busy ? bcnt + 1'b1 : '0;
            if (take) begin
                c_page <= req_page;
                c_lock <= wp_in && req_page[PG_W-1];
            end
        end
    end

    a_r3_busy_full_length: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> (bcnt == BC_W'(BUSY_CYCLES)));

    a_r3_busy_not_longer: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bcnt < BC_W'(BUSY_CYCLES)));

    a_r2_start_needs_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid && stop_det));

    a_r7_locked_no_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !c_lock);

    a_r6_stay_in_page: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr[ADDR_W-1:OFS_W] == c_page));

    a_r10_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wr_en);

    a_r10_ascending: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && $past(busy) && !$past(rst)) |-> (wr_addr > $past(wr_addr)));
endmodule

bind pgcommit_engine pgc_checker #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_pgc_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .stop_det(stop_det),
    .req_page(req_page), .wp_in(wp_in), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/pgcommit_engine_bench.sv
module pgcommit_engine_bench;
    localparam int PERIOD = 10;
    localparam int BC     = 24;
    localparam int NVEC   = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid, stop_det, wp_in;
    logic [2:0]   req_page;
    logic [127:0] req_data;
    logic [15:0]  req_mask;
    logic         busy;
    logic [6:0]   rd_addr;
    logic [7:0]   rd_data;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    logic [7:0] model [128];

    always #(PERIOD/2) clk = ~clk;

    pgcommit_engine #(.BUSY_CYCLES(BC)) u_pgcommit_engine (
        .clk(clk), .rst(rst), .req_valid(req_valid), .stop_det(stop_det),
        .req_page(req_page), .req_data(req_data), .req_mask(req_mask),
        .wp_in(wp_in), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Each entry: {page[2:0], mask[15:0], lock, stop, seed[7:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {3'd0, 16'hFFFF, 1'b0, 1'b1, 8'h10},
        {3'd4, 16'hFFFF, 1'b1, 1'b1, 8'h20},
        {3'd4, 16'h00F0, 1'b0, 1'b1, 8'h30},
        {3'd1, 16'h8001, 1'b1, 1'b1, 8'h40},
        {3'd7, 16'hFFFF, 1'b1, 1'b1, 8'h50},
        {3'd7, 16'hA5A5, 1'b0, 1'b1, 8'h60},
        {3'd2, 16'hFFFF, 1'b0, 1'b0, 8'h70},
        {3'd3, 16'h0000, 1'b0, 1'b1, 8'h80}
    };

    function automatic logic [127:0] make_data(input logic [7:0] seed);
        logic [127:0] d;
        for (int i = 0; i < 16; i++) d[i*8 +: 8] = seed + 8'(7 * i);
        return d;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk) rd_addr = a;
        @(negedge clk) v = rd_data;
    endtask

    task automatic model_commit(input logic [2:0] pg, input logic [15:0] m,
                                input logic lock, input logic [7:0] seed);
        logic [127:0] d;
        d = make_data(seed);
        if (!(lock && pg[2]))
            for (int i = 0; i < 16; i++)
                if (m[i]) model[{pg, 4'(i)}] = d[i*8 +: 8];
    endtask

    task automatic verify_page(input logic [2:0] pg, input string tag);
        logic [7:0] v;
        for (int o = 0; o < 16; o++) begin
            rd({pg, 4'(o)}, v);
            check(v == model[{pg, 4'(o)}], tag, v, model[{pg, 4'(o)}]);
        end
    endtask

    // Issues one request, returns the number of cycles busy was seen high.
    task automatic commit(input logic [2:0] pg, input logic [15:0] m, input logic lock,
                          input logic stp, input logic [7:0] seed, output int n);
        @(negedge clk);
        req_page = pg; req_mask = m; wp_in = lock; stop_det = stp;
        req_data = make_data(seed); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; stop_det = 1'b0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] v;
        for (int i = 0; i < 128; i++) model[i] = 8'hFF;
        rst = 1'b1; req_valid = 0; stop_det = 0; wp_in = 0; req_page = 0;
        req_mask = 0; req_data = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        rd(7'h00, v); check(v == 8'hFF, "R1 erased 00h", v, 8'hFF);
        rd(7'h7F, v); check(v == 8'hFF, "R1 erased 7Fh", v, 8'hFF);

        // Vector table: R2 (no stop), R3 busy length, R5/R8 data, R7 locked
        for (int k = 0; k < NVEC; k++) begin
            logic [2:0] pg; logic [15:0] m; logic lk, st; logic [7:0] sd;
            {pg, m, lk, st, sd} = VEC[k];
            commit(pg, m, lk, st, sd, n);
            if (st) model_commit(pg, m, lk, sd);
            if (!st)             check(n == 0, "R2 busy without stop", n, 0);
            else if (lk && pg[2]) check(n == BC, "R7 busy while locked", n, BC);
            else                 check(n == BC, "R3 busy length", n, BC);
            if (!st)              verify_page(pg, "R2 ignored request");
            else if (lk && pg[2]) verify_page(pg, "R7 locked page");
            else if (lk)          verify_page(pg, "R8 lower half with lock");
            else                  verify_page(pg, "R5 masked bytes (R10 ascending sparse)");
        end

        // R4: second request during busy refused
        @(negedge clk);
        req_page = 3'd6; req_mask = 16'hFFFF; wp_in = 0; stop_det = 1;
        req_data = make_data(8'h90); req_valid = 1;
        @(negedge clk);
        req_valid = 0; stop_det = 0; n = 0;
        repeat (3) begin if (busy) n++; @(negedge clk); end
        req_page = 3'd2; req_data = make_data(8'hAA); stop_det = 1; req_valid = 1;
        if (busy) n++;
        @(negedge clk);
        req_valid = 0; stop_det = 0;
        while (busy) begin n++; @(negedge clk); end
        model_commit(3'd6, 16'hFFFF, 1'b0, 8'h90);
        check(n == BC, "R4 busy not extended", n, BC);
        verify_page(3'd2, "R4 refused request");
        verify_page(3'd6, "R4 first commit");

        // R9: lock raised after acceptance has no effect
        @(negedge clk);
        req_page = 3'd5; req_mask = 16'h0FF0; wp_in = 0; stop_det = 1;
        req_data = make_data(8'hC0); req_valid = 1;
        @(negedge clk);
        req_valid = 0; stop_det = 0; wp_in = 1; n = 0;
        while (busy) begin n++; @(negedge clk); end
        model_commit(3'd5, 16'h0FF0, 1'b0, 8'hC0);
        check(n == BC, "R9 busy length", n, BC);
        verify_page(3'd5, "R9 lock sampled at accept");
        commit(3'd5, 16'hFFFF, 1'b1, 1'b1, 8'hD0, n);
        verify_page(3'd5, "R7 lock now set");

        // R6: nothing outside the addressed pages changed
        for (int a = 0; a < 128; a++) begin
            rd(7'(a), v);
            check(v == model[a], "R6 whole array", v, model[a]);
        end

        // R1: reset in the middle of a commit
        @(negedge clk);
        req_page = 3'd0; req_mask = 16'hFFFF; wp_in = 0; stop_det = 1;
        req_data = make_data(8'h01); req_valid = 1;
        @(negedge clk);
        req_valid = 0; stop_det = 0;
        repeat (2) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        check(busy == 1'b0, "R1 busy after mid reset", busy, 0);
        rd(7'h03, v); check(v == 8'hFF, "R1 erased after mid reset", v, 8'hFF);
        rd(7'h60, v); check(v == 8'hFF, "R1 erased after mid reset", v, 8'hFF);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule